// File: doc/BRIEF.md
# CGRA Processing Element Datapath

This block is one compute tile of a coarse-grained reconfigurable array. On every clock edge it executes one 32-bit configuration word. It picks up to three operands, computes one result with single-cycle latency, and then updates its registered output, its four-entry local register file and its memory-bus strobes. The output feeds the neighbouring tiles and the memory port. The array fabric, the memory and the configuration fetch sit outside the block.

Bit 27 of the word sets the format. In the regular format (bit 27 = 0) the word carries write-back and bus-strobe fields. In the predicated format (bit 27 = 1) those bit positions instead name a third operand, the predicate. Each operand comes through its own 8-way source selector. The selector can choose a local register, one of the four neighbours, the data bus, the sign-extended immediate, or the tile's own output latch. The datapath has no control state of its own. The only state is the output latch, the bus-strobe flops and the register file, so each word depends only on that state and on the current inputs.

Top module: `cgra_pe`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `pe_out` reads 0 and both strobes read 0. All four local registers read 0.
- R2: Regular-format word fields: opcode in bits 31:28, format bit 27 = 0, left select in 26:24, right select in 23:21, left register index in 20:19, right register index in 18:17, write register in 16:15, write enable in bit 14, address strobe in bit 13, data strobe in bit 12, immediate in 11:0. The arithmetic and logic opcodes are 0 add, 1 subtract, 2 multiply (low 32 bits of the signed product), 3 and, 4 or and 5 xor. Each result appears on `pe_out` one cycle after the word.
- R3: Source select codes, used for every operand: 0 local register, 1 west neighbour, 2 east neighbour, 3 north neighbour, 4 south neighbour, 5 data bus, 6 immediate, 7 own output latch.
- R4: An operand's register index has an effect only when that operand's select is 0. The 12-bit immediate is sign-extended to 32 bits.
- R5: The compare opcodes are 12 equal, 13 not-equal, 14 signed greater-than and 15 signed less-than. Each yields 1 when true and 0 when false.
- R6: Opcode 9 is signed divide and opcode 10 is signed remainder, with the remainder taking the dividend's sign. When the divisor is 0, both yield 0. The most negative value divided by -1 gives the most negative value, with a remainder of 0.
- R7: The shift opcodes are 6 arithmetic right, 8 left and 11 logical right. The shift amount is bits 4:0 of the right operand.
- R8: The output latch holds its value on regular opcode 7. It also holds on predicated opcodes 0 (configuration boundary) and 7, and on the reserved predicated opcodes 9 to 15.
- R9: A local register is written only by a regular-format word with write enable set and an opcode other than 7. The register named in bits 16:15 then receives the result. Predicated-format words never write a register.
- R10: `addr_en` and `data_en` follow bits 13 and 12 of a regular-format word one cycle later. After any predicated-format word both strobes are 0.
- R11: Predicated load opcodes, with the immediate in bits 11:0: opcode 1 loads the sign-extended immediate. Opcode 2 replaces output bits 23:12 with the immediate. Opcode 3 replaces output bits 31:24 with immediate bits 7:0. All other output bits hold.
- R12: Predicated opcode 4 selects between two operands. The predicate operand comes from the select in bits 14:12 and the register index in bits 16:15. When the predicate is non-zero the output takes the left operand, otherwise the right.
- R13: Predicated opcode 5 yields 1 when left ≥ right (signed) and 0 otherwise. Opcode 6 yields left + right. Opcode 8 sign-extends the left operand from bit 7 when immediate bit 0 is 0, and from bit 15 when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 32 | Configuration word executed this cycle |
| nbr_west | input | 32 | West neighbour output (source 1) |
| nbr_east | input | 32 | East neighbour output (source 2) |
| nbr_north | input | 32 | North neighbour output (source 3) |
| nbr_south | input | 32 | South neighbour output (source 4) |
| bus_rdata | input | 32 | Data bus read value (source 5) |
| pe_out | output | 32 | Registered result latch |
| addr_en | output | 1 | Registered address-bus strobe |
| data_en | output | 1 | Registered data-bus strobe |

## Verification
A fault in the output latch shows on `pe_out` at the very next sample. A fault in the strobe flops shows the same way on `addr_en` and `data_en`. A corrupted local register stays hidden until a later word selects it through source 0, so the stimulus writes registers and then reads them back through an add with a zero immediate. The same read-back confirms the cases where no write should occur. Random words run against a bench model whose registers and latch evolve with the design, so a wrong write surfaces on the first later word that reads the damaged register, usually within a few cycles.

// File: rtl/pe_pkg.sv
package pe_pkg;

    localparam int WORD_W = 32;
    localparam int IMM_W  = 12;
    localparam int SEL_W  = 3;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);
    localparam int NOPND  = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_REG   = 3'd0,
        SRC_WEST  = 3'd1,
        SRC_EAST  = 3'd2,
        SRC_NORTH = 3'd3,
        SRC_SOUTH = 3'd4,
        SRC_BUS   = 3'd5,
        SRC_IMM   = 3'd6,
        SRC_SELF  = 3'd7
    } src_e;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_MUL = 4'd2,  OP_AND = 4'd3,
        OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_ASR = 4'd6,  OP_NOP = 4'd7,
        OP_SHL = 4'd8,  OP_DIV = 4'd9,  OP_REM = 4'd10, OP_LSR = 4'd11,
        OP_EQ  = 4'd12, OP_NE  = 4'd13, OP_GT  = 4'd14, OP_LT  = 4'd15
    } rop_e;

    typedef enum logic [3:0] {
        PO_BOUND = 4'd0,  PO_LDLO  = 4'd1,  PO_LDMID = 4'd2,  PO_LDHI  = 4'd3,
        PO_SEL   = 4'd4,  PO_LEXIT = 4'd5,  PO_AGEN  = 4'd6,  PO_NOP   = 4'd7,
        PO_SEXT  = 4'd8,  PO_RSV9  = 4'd9,  PO_RSV10 = 4'd10, PO_RSV11 = 4'd11,
        PO_RSV12 = 4'd12, PO_RSV13 = 4'd13, PO_RSV14 = 4'd14, PO_RSV15 = 4'd15
    } pop_e;

    typedef struct packed {
        logic              pfmt;
        logic [3:0]        opc;
        src_e              lsel;
        src_e              rsel;
        src_e              psel;
        logic [RIDX_W-1:0] lidx;
        logic [RIDX_W-1:0] ridx;
        logic [RIDX_W-1:0] pidx;
        logic [RIDX_W-1:0] widx;
        logic              wen;
        logic              aen;
        logic              den;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    // Field split of one configuration word; bit 27 chooses the layout.
    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        d.pfmt = w[27];
        d.opc  = w[31:28];
        d.lsel = src_e'(w[26:24]);
        d.rsel = src_e'(w[23:21]);
        d.lidx = w[20:19];
        d.ridx = w[18:17];
        d.widx = w[16:15];
        d.pidx = w[16:15];
        d.imm  = w[IMM_W-1:0];
        if (w[27]) begin
            d.psel = src_e'(w[14:12]);
            d.wen  = 1'b0;
            d.aen  = 1'b0;
            d.den  = 1'b0;
        end else begin
            d.psel = SRC_IMM;
            d.wen  = w[14];
            d.aen  = w[13];
            d.den  = w[12];
        end
        return d;
    endfunction

endpackage

// File: rtl/pe_regfile.sv
module pe_regfile
    import pe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = NREG,
    parameter int NRD    = NOPND
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NRD-1:0][RIDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    input  logic                         wr_en,
    input  logic [RIDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]            wr_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rd_data[g] = mem[rd_idx[g]];
        end
        for (genvar e = 0; e < DEPTH; e++) begin : g_chk
            assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == RIDX_W'(e)) |=> $stable(mem[e]));
        end
    endgenerate

endmodule

// File: rtl/pe_opsel.sv
module pe_opsel
    import pe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] west,
    input  logic [DATA_W-1:0] east,
    input  logic [DATA_W-1:0] north,
    input  logic [DATA_W-1:0] south,
    input  logic [DATA_W-1:0] bus,
    input  logic [DATA_W-1:0] imm_ext,
    input  logic [DATA_W-1:0] self_val,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        unique case (src_e'(sel))
            SRC_REG:   opnd = reg_val;
            SRC_WEST:  opnd = west;
            SRC_EAST:  opnd = east;
            SRC_NORTH: opnd = north;
            SRC_SOUTH: opnd = south;
            SRC_BUS:   opnd = bus;
            SRC_IMM:   opnd = imm_ext;
            SRC_SELF:  opnd = self_val;
        endcase
    end

endmodule

// File: rtl/pe_alu.sv
module pe_alu
    import pe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              pfmt,
    input  logic [3:0]        opc,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] opp,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] res,
    output logic              upd
);

    localparam int SH_W = $clog2(DATA_W);
    localparam int MID_LO = IMM_W;
    localparam int MID_HI = 2 * IMM_W - 1;
    localparam int HI_W = DATA_W - 2 * IMM_W;
    localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] sa, sb;
    logic [SH_W-1:0]          shamt;
    logic [DATA_W-1:0]        quo, rmd;
    logic [DATA_W-1:0]        imm_ext;

    assign sa      = $signed(opa);
    assign sb      = $signed(opb);
    assign shamt   = opb[SH_W-1:0];
    assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

    // Guarded division: zero divisor and the single overflow pair.
    always_comb begin
        if (opb == '0) begin
            quo = '0;
            rmd = '0;
        end else if (opa == MIN_VAL && opb == '1) begin
            quo = MIN_VAL;
            rmd = '0;
        end else begin
            quo = sa / sb;
            rmd = sa % sb;
        end
    end

    always_comb begin
        res = cur;
        upd = 1'b1;
        if (!pfmt) begin
            unique case (rop_e'(opc))
                OP_ADD: res = opa + opb;
                OP_SUB: res = opa - opb;
                OP_MUL: res = sa * sb;
                OP_AND: res = opa & opb;
                OP_OR:  res = opa | opb;
                OP_XOR: res = opa ^ opb;
                OP_ASR: res = sa >>> shamt;
                OP_NOP: upd = 1'b0;
                OP_SHL: res = opa << shamt;
                OP_DIV: res = quo;
                OP_REM: res = rmd;
                OP_LSR: res = opa >> shamt;
                OP_EQ:  res = {{(DATA_W-1){1'b0}}, opa == opb};
                OP_NE:  res = {{(DATA_W-1){1'b0}}, opa != opb};
                OP_GT:  res = {{(DATA_W-1){1'b0}}, sa > sb};
                OP_LT:  res = {{(DATA_W-1){1'b0}}, sa < sb};
            endcase
        end else begin
            unique case (pop_e'(opc))
                PO_LDLO:  res = imm_ext;
                PO_LDMID: res[MID_HI:MID_LO] = imm;
                PO_LDHI:  res[DATA_W-1:2*IMM_W] = imm[HI_W-1:0];
                PO_SEL:   res = (opp != '0) ? opa : opb;
                PO_LEXIT: res = {{(DATA_W-1){1'b0}}, sa >= sb};
                PO_AGEN:  res = opa + opb;
                PO_SEXT:  res = imm[0] ? {{(DATA_W-16){opa[15]}}, opa[15:0]}
                                       : {{(DATA_W-8){opa[7]}}, opa[7:0]};
                PO_BOUND, PO_NOP, PO_RSV9, PO_RSV10, PO_RSV11,
                PO_RSV12, PO_RSV13, PO_RSV14, PO_RSV15: upd = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cgra_pe.sv
module cgra_pe
    import pe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] nbr_west,
    input  logic [DATA_W-1:0] nbr_east,
    input  logic [DATA_W-1:0] nbr_north,
    input  logic [DATA_W-1:0] nbr_south,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pe_out,
    output logic              addr_en,
    output logic              data_en
);

    dec_t                             dec;
    logic [NOPND-1:0][SEL_W-1:0]      src_sel;
    logic [NOPND-1:0][RIDX_W-1:0]     src_idx;
    logic [NOPND-1:0][DATA_W-1:0]     reg_rd;
    logic [NOPND-1:0][DATA_W-1:0]     opnd;
    logic [DATA_W-1:0]                imm_ext;
    logic [DATA_W-1:0]                alu_res;
    logic                             alu_upd;
    logic                             rf_we;

    assign dec     = decode_word(cfg_word);
    assign imm_ext = {{(DATA_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
    assign src_sel = {dec.psel, dec.rsel, dec.lsel};
    assign src_idx = {dec.pidx, dec.ridx, dec.lidx};
    assign rf_we   = !dec.pfmt && dec.wen && (dec.opc != OP_NOP);

    pe_regfile #(.DATA_W(DATA_W), .DEPTH(NREG), .NRD(NOPND)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (src_idx),
        .rd_data (reg_rd),
        .wr_en   (rf_we),
        .wr_idx  (dec.widx),
        .wr_data (alu_res)
    );

    generate
        for (genvar g = 0; g < NOPND; g++) begin : g_opsel
            pe_opsel #(.DATA_W(DATA_W)) u_sel (
                .sel      (src_sel[g]),
                .reg_val  (reg_rd[g]),
                .west     (nbr_west),
                .east     (nbr_east),
                .north    (nbr_north),
                .south    (nbr_south),
                .bus      (bus_rdata),
                .imm_ext  (imm_ext),
                .self_val (pe_out),
                .opnd     (opnd[g])
            );
        end
    endgenerate

    pe_alu #(.DATA_W(DATA_W)) u_alu (
        .pfmt (dec.pfmt),
        .opc  (dec.opc),
        .opa  (opnd[0]),
        .opb  (opnd[1]),
        .opp  (opnd[2]),
        .imm  (dec.imm),
        .cur  (pe_out),
        .res  (alu_res),
        .upd  (alu_upd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_out <= '0;
        end else if (alu_upd) begin
            pe_out <= alu_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_en <= 1'b0;
            data_en <= 1'b0;
        end else begin
            addr_en <= dec.aen;
            data_en <= dec.den;
        end
    end

    assert_nop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[27] && cfg_word[31:28] == 4'd7) |=> $stable(pe_out));

    assert_cmp_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[27] && cfg_word[31:30] == 2'b11) |=> (pe_out[DATA_W-1:1] == '0));

    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[27] && (cfg_word[31:28] == 4'd9 || cfg_word[31:28] == 4'd10)
         && opnd[1] == '0) |=> (pe_out == '0));

    assert_pfmt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[27] |=> (!addr_en && !data_en));

    assert_addr_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_word[27] && cfg_word[13]) |=> addr_en);

endmodule

// File: tb/test_cgra_pe.sv
module test_cgra_pe;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [31:0] in_w = '0, in_e = '0, in_n = '0, in_s = '0, in_bus = '0;
    logic [31:0] pe_out;
    logic        addr_en, data_en;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_reg [4];
    logic [31:0] m_out;
    logic        m_aen, m_den;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgra_pe i_cgra_pe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg_word),
        .nbr_west  (in_w),
        .nbr_east  (in_e),
        .nbr_north (in_n),
        .nbr_south (in_s),
        .bus_rdata (in_bus),
        .pe_out    (pe_out),
        .addr_en   (addr_en),
        .data_en   (data_en)
    );

    function automatic logic [31:0] rw(input logic [3:0] op, input logic [2:0] ls, input logic [2:0] rs,
                                       input logic [1:0] li, input logic [1:0] ri, input logic [1:0] wi,
                                       input logic we, input logic ab, input logic db, input logic [11:0] imm);
        return {op, 1'b0, ls, rs, li, ri, wi, we, ab, db, imm};
    endfunction

    function automatic logic [31:0] pw(input logic [3:0] op, input logic [2:0] ls, input logic [2:0] rs,
                                       input logic [1:0] li, input logic [1:0] ri, input logic [1:0] pi,
                                       input logic [2:0] ps, input logic [11:0] imm);
        return {op, 1'b1, ls, rs, li, ri, pi, ps, imm};
    endfunction

    function automatic logic [31:0] pick(input logic [2:0] s, input logic [1:0] idx, input logic [11:0] imm);
        case (s)
            3'd0: return m_reg[idx];
            3'd1: return in_w;
            3'd2: return in_e;
            3'd3: return in_n;
            3'd4: return in_s;
            3'd5: return in_bus;
            3'd6: return {{20{imm[11]}}, imm};
            default: return m_out;
        endcase
    endfunction

    function automatic void model(input logic pf, input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [31:0] p, input logic [11:0] imm,
                                  output logic [31:0] res, output logic upd);
        upd = 1'b1;
        res = m_out;
        if (!pf) begin
            case (op)
                4'd0:  res = a + b;
                4'd1:  res = a - b;
                4'd2:  res = 32'($signed(a) * $signed(b));
                4'd3:  res = a & b;
                4'd4:  res = a | b;
                4'd5:  res = a ^ b;
                4'd6:  res = 32'($signed(a) >>> b[4:0]);
                4'd7:  upd = 1'b0;
                4'd8:  res = a << b[4:0];
                4'd9, 4'd10: begin
                    if (b == 0) res = 0;
                    else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) res = (op == 4'd9) ? a : 0;
                    else res = (op == 4'd9) ? 32'($signed(a) / $signed(b)) : 32'($signed(a) % $signed(b));
                end
                4'd11: res = a >> b[4:0];
                4'd12: res = (a == b) ? 1 : 0;
                4'd13: res = (a != b) ? 1 : 0;
                4'd14: res = ($signed(a) > $signed(b)) ? 1 : 0;
                default: res = ($signed(a) < $signed(b)) ? 1 : 0;
            endcase
        end else begin
            case (op)
                4'd1: res = {{20{imm[11]}}, imm};
                4'd2: res = {m_out[31:24], imm, m_out[11:0]};
                4'd3: res = {imm[7:0], m_out[23:0]};
                4'd4: res = (p != 0) ? a : b;
                4'd5: res = ($signed(a) >= $signed(b)) ? 1 : 0;
                4'd6: res = a + b;
                4'd8: res = imm[0] ? {{16{a[15]}}, a[15:0]} : {{24{a[7]}}, a[7:0]};
                default: upd = 1'b0;
            endcase
        end
    endfunction

    function automatic string req_of(input logic [31:0] w);
        if (!w[27]) begin
            case (w[31:28])
                4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R2";
                4'd6, 4'd8, 4'd11: return "R7";
                4'd7: return "R8";
                4'd9, 4'd10: return "R6";
                default: return "R5";
            endcase
        end
        case (w[31:28])
            4'd1, 4'd2, 4'd3: return "R11";
            4'd4: return "R12";
            4'd5, 4'd6, 4'd8: return "R13";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] rnd_data();
        case ($urandom % 4)
            0: return $urandom % 16;
            1: return 32'd0 - ($urandom % 16);
            2: begin
                case ($urandom % 4)
                    0: return 32'h8000_0000;
                    1: return 32'h7FFF_FFFF;
                    2: return 32'hFFFF_FFFF;
                    default: return 32'd0;
                endcase
            end
            default: return $urandom;
        endcase
    endfunction

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns at the next falling edge.
    task automatic apply(input logic [31:0] w, input string req);
        logic [31:0] a, b, p, res;
        logic        upd;
        a = pick(w[26:24], w[20:19], w[11:0]);
        b = pick(w[23:21], w[18:17], w[11:0]);
        p = w[27] ? pick(w[14:12], w[16:15], w[11:0]) : 32'd0;
        model(w[27], w[31:28], a, b, p, w[11:0], res, upd);
        if (!w[27] && w[14] && w[31:28] != 4'd7) m_reg[w[16:15]] = res;
        if (upd) m_out = res;
        m_aen = !w[27] && w[13];
        m_den = !w[27] && w[12];
        cfg_word = w;
        @(posedge clk);
        @(negedge clk);
        check_val(req, pe_out, m_out);
        check_val({req, " addr_en"}, {31'd0, addr_en}, {31'd0, m_aen});
        check_val({req, " data_en"}, {31'd0, data_en}, {31'd0, m_den});
    endtask

    task automatic set_nbr(input logic [31:0] w, input logic [31:0] e);
        in_w = w;
        in_e = e;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]  order [8];
        logic [31:0] exps  [8];
        void'($urandom(32'd1357));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_out = '0;
        m_aen = 1'b0;
        m_den = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1 out in reset", pe_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 out", pe_out, 32'd0);
        check_val("R1 addr_en", {31'd0, addr_en}, 32'd0);
        check_val("R1 data_en", {31'd0, data_en}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            apply(rw(4'd0, 3'd0, 3'd6, 2'(k), 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R1");
            check_val("R1 reg read", pe_out, 32'd0);
        end

        // R3: every source code
        in_w = 32'd11; in_e = 32'd22; in_n = 32'd33; in_s = 32'd44; in_bus = 32'd55;
        apply(rw(4'd0, 3'd6, 3'd0, 2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 12'd77), "R3");
        order = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7, 3'd6};
        exps  = '{32'd77, 32'd11, 32'd22, 32'd33, 32'd44, 32'd55, 32'd55, 32'd0};
        for (int s = 0; s < 8; s++) begin
            apply(rw(4'd0, order[s], 3'd6, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R3");
            check_val("R3 source", pe_out, exps[s]);
        end

        // R4: index ignored off source 0, immediate sign extension
        apply(rw(4'd0, 3'd6, 3'd6, 2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 12'hFFF), "R4");
        check_val("R4 imm not reg", pe_out, 32'hFFFF_FFFE);

        // R2: arithmetic and logic
        set_nbr(32'hFFFF_FFF9, 32'd3);
        apply(rw(4'd0, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R2");
        check_val("R2 add", pe_out, 32'hFFFF_FFFC);
        apply(rw(4'd1, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R2");
        check_val("R2 sub", pe_out, 32'hFFFF_FFF6);
        apply(rw(4'd2, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R2");
        check_val("R2 mul", pe_out, 32'hFFFF_FFEB);
        apply(rw(4'd3, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R2");
        check_val("R2 and", pe_out, 32'd1);
        apply(rw(4'd4, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R2");
        check_val("R2 or", pe_out, 32'hFFFF_FFFB);
        apply(rw(4'd5, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R2");
        check_val("R2 xor", pe_out, 32'hFFFF_FFFA);

        // R7: shift amount from low five bits (33 -> 1)
        set_nbr(32'h8000_0010, 32'd33);
        apply(rw(4'd6, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R7");
        check_val("R7 asr", pe_out, 32'hC000_0008);
        apply(rw(4'd8, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R7");
        check_val("R7 shl", pe_out, 32'h0000_0020);
        apply(rw(4'd11, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R7");
        check_val("R7 lsr", pe_out, 32'h4000_0008);

        // R6: division corners
        set_nbr(32'hFFFF_FFF9, 32'd2);
        apply(rw(4'd9, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R6");
        check_val("R6 div", pe_out, 32'hFFFF_FFFD);
        apply(rw(4'd10, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R6");
        check_val("R6 rem", pe_out, 32'hFFFF_FFFF);
        set_nbr(32'd9, 32'd0);
        apply(rw(4'd9, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R6");
        check_val("R6 div by zero", pe_out, 32'd0);
        apply(rw(4'd10, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R6");
        check_val("R6 rem by zero", pe_out, 32'd0);
        set_nbr(32'h8000_0000, 32'hFFFF_FFFF);
        apply(rw(4'd9, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R6");
        check_val("R6 min div -1", pe_out, 32'h8000_0000);
        apply(rw(4'd10, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R6");
        check_val("R6 min rem -1", pe_out, 32'd0);

        // R5: signed compares
        set_nbr(32'hFFFF_FFFF, 32'd1);
        apply(rw(4'd12, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R5");
        check_val("R5 eq", pe_out, 32'd0);
        apply(rw(4'd13, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R5");
        check_val("R5 ne", pe_out, 32'd1);
        apply(rw(4'd14, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R5");
        check_val("R5 gt signed", pe_out, 32'd0);
        apply(rw(4'd15, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R5");
        check_val("R5 lt signed", pe_out, 32'd1);
        set_nbr(32'd5, 32'd5);
        apply(rw(4'd12, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R5");
        check_val("R5 eq true", pe_out, 32'd1);

        // R11: build 0x12345678 in three loads
        apply(pw(4'd1, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 3'd0, 12'hFFF), "R11");
        check_val("R11 ldlo sext", pe_out, 32'hFFFF_FFFF);
        apply(pw(4'd1, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 3'd0, 12'h678), "R11");
        check_val("R11 ldlo", pe_out, 32'h0000_0678);
        apply(pw(4'd2, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 3'd0, 12'h345), "R11");
        check_val("R11 ldmid", pe_out, 32'h0034_5678);
        apply(pw(4'd3, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 3'd0, 12'hF12), "R11");
        check_val("R11 ldhi", pe_out, 32'h1234_5678);

        // R8: hold on every no-update opcode; R9 write suppressed on nop
        apply(rw(4'd7, 3'd6, 3'd6, 2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 12'd5), "R8");
        check_val("R8 nop hold", pe_out, 32'h1234_5678);
        apply(pw(4'd0, 3'd6, 3'd6, 2'd0, 2'd0, 2'd0, 3'd6, 12'd5), "R8");
        check_val("R8 boundary hold", pe_out, 32'h1234_5678);
        apply(pw(4'd7, 3'd6, 3'd6, 2'd0, 2'd0, 2'd0, 3'd6, 12'd5), "R8");
        check_val("R8 pnop hold", pe_out, 32'h1234_5678);
        apply(pw(4'd12, 3'd6, 3'd6, 2'd0, 2'd0, 2'd0, 3'd6, 12'd5), "R8");
        check_val("R8 reserved hold", pe_out, 32'h1234_5678);
        apply(rw(4'd0, 3'd0, 3'd6, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R9");
        check_val("R9 nop no write", pe_out, 32'd77);

        // R9: write enable and format gate the register write
        apply(rw(4'd0, 3'd6, 3'd0, 2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 12'd5), "R9");
        apply(rw(4'd0, 3'd0, 3'd6, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R9");
        check_val("R9 we=0 no write", pe_out, 32'd0);
        apply(pw(4'd1, 3'd0, 3'd0, 2'd0, 2'd0, 2'd2, 3'd4, 12'd9), "R9");
        apply(rw(4'd0, 3'd0, 3'd6, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R9");
        check_val("R9 pfmt no write", pe_out, 32'd0);
        apply(rw(4'd0, 3'd6, 3'd0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 12'd5), "R9");
        apply(rw(4'd0, 3'd0, 3'd6, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0), "R9");
        check_val("R9 write", pe_out, 32'd5);

        // R10: strobes
        apply(rw(4'd0, 3'd6, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 12'd1), "R10");
        check_val("R10 addr strobe", {30'd0, addr_en, data_en}, 32'd2);
        apply(rw(4'd0, 3'd6, 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 12'd1), "R10");
        check_val("R10 data strobe", {30'd0, addr_en, data_en}, 32'd1);
        apply(pw(4'd6, 3'd6, 3'd6, 2'd0, 2'd0, 2'd0, 3'd3, 12'd1), "R10");
        check_val("R10 pfmt quiet", {30'd0, addr_en, data_en}, 32'd0);

        // R12: select with predicate from register, immediate, bus
        set_nbr(32'd100, 32'd200);
        in_bus = 32'd0;
        apply(pw(4'd4, 3'd1, 3'd2, 2'd0, 2'd0, 2'd3, 3'd0, 12'd0), "R12");
        check_val("R12 pred reg zero", pe_out, 32'd200);
        apply(pw(4'd4, 3'd1, 3'd2, 2'd0, 2'd0, 2'd3, 3'd6, 12'd1), "R12");
        check_val("R12 pred imm", pe_out, 32'd100);
        apply(pw(4'd4, 3'd1, 3'd2, 2'd0, 2'd0, 2'd3, 3'd5, 12'd1), "R12");
        check_val("R12 pred bus zero", pe_out, 32'd200);
        apply(pw(4'd4, 3'd1, 3'd2, 2'd0, 2'd0, 2'd2, 3'd0, 12'd0), "R12");
        check_val("R12 pred reg set", pe_out, 32'd100);

        // R13: loop exit, address generator, sign extension
        set_nbr(32'd5, 32'd5);
        apply(pw(4'd5, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 3'd0, 12'd0), "R13");
        check_val("R13 lexit eq", pe_out, 32'd1);
        set_nbr(32'd4, 32'd5);
        apply(pw(4'd5, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 3'd0, 12'd0), "R13");
        check_val("R13 lexit lt", pe_out, 32'd0);
        set_nbr(32'd100, 32'hFFFF_FFFC);
        apply(pw(4'd6, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 3'd0, 12'd0), "R13");
        check_val("R13 agen", pe_out, 32'd96);
        set_nbr(32'h0000_8080, 32'd0);
        apply(pw(4'd8, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 3'd0, 12'd0), "R13");
        check_val("R13 sext byte", pe_out, 32'hFFFF_FF80);
        apply(pw(4'd8, 3'd1, 3'd2, 2'd0, 2'd0, 2'd0, 3'd0, 12'd1), "R13");
        check_val("R13 sext half", pe_out, 32'hFFFF_8080);

        // Random words against the bench model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            w = $urandom;
            in_w = rnd_data(); in_e = rnd_data(); in_n = rnd_data();
            in_s = rnd_data(); in_bus = rnd_data();
            apply(w, req_of(w));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule